// File: doc/BRIEF.md
# Scatter-Gather Bus-Master DMA Engine

This block is the bus-master DMA controller of one disk channel. Software places a table of 8-byte region descriptors in system memory, loads the table's base address into the engine one byte at a time, and then the device side requests a transfer in one of two directions. In the inbound direction, bytes flow from the device stream into memory. In the outbound direction, bytes flow from memory to the device stream. The engine fetches one descriptor and moves the bytes of that region. It then steps to the next descriptor, and it keeps going until it has finished the entry whose end flag is set.

Memory is reached through a byte-wide request/acknowledge port that carries both the descriptor fetches and the data moves. The device side has a valid/ready byte stream in each direction. When a transfer finishes, the engine drops its active flag and sets a sticky interrupt flag that software clears by writing a one to it. It also reports the device's task-file status as ready and, unless interrupts are masked, pulses its interrupt output. The sticky flag is also set by unmasked device interrupts and by a software kick through the command register, so a polling driver sees every event.

Top module: `bmdma_engine`

## Requirements
- R1: After reset, the status register reads 0x00, every byte of the table pointer reads 0x00, `tf_status` is 0x50 and `irq` is low.
- R2: The table pointer is written and read one byte at a time. Offset 4 holds bits 7:0, offset 5 bits 15:8, offset 6 bits 23:16 and offset 7 bits 31:24. A write to one offset leaves the other bytes unchanged.
- R3: Reading the command register (offset 0) returns 0x01. Writing it with bit 0 set, while `irq_mask` is low, pulses `irq` for one cycle and sets the interrupt flag. Writing it with bit 0 clear has no effect.
- R4: The status register is at offset 2, with the active flag at bit 0 and the interrupt flag at bit 2. Writing a 1 to bit 2 clears the interrupt flag, and writing a 0 there leaves it set.
- R5: A `xfer_start` pulse while idle sets the active flag and drives `tf_status` to 0x80 from the next cycle until completion.
- R6: A descriptor is 8 bytes at table pointer + 8·k. Bytes 0..3 give the little-endian buffer address, bytes 4..5 the little-endian byte count, and bit 7 of byte 7 marks the last entry. Inbound data fills each region in order at consecutive addresses and writes nothing past the region.
- R7: A descriptor count of 0 describes 65536 bytes.
- R8: If the device marks its final inbound byte with `dev_in_last` before the descriptors are used up, the engine stops after writing that byte, clears the active flag and sets the interrupt flag.
- R9: In the outbound direction, every described byte is handed to the device in table order, and completion (`tf_status` back to 0x50) occurs only after the device has accepted the last byte.
- R10: On completion the active flag clears, the interrupt flag sets and `tf_status` returns to 0x50. `irq` pulses exactly once, and not at all while `irq_mask` is high.
- R11: A `dev_irq` pulse while `irq_mask` is low pulses `irq` and sets the interrupt flag. While `irq_mask` is high, it does neither.
- R12: When a set event and a write clearing the interrupt flag fall in the same cycle, the flag ends up set.
- R13: A `xfer_start` pulse while a transfer is active is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| xfer_start | input | 1 | Transfer request pulse from the device side |
| xfer_dir | input | 1 | 0 = device to memory, 1 = memory to device |
| irq_mask | input | 1 | Suppresses interrupt pulses when high |
| dev_irq | input | 1 | Device interrupt event |
| irq | output | 1 | Interrupt pulse |
| tf_status | output | 8 | Task-file status: 0x80 busy, 0x50 ready |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid with ack |
| mem_ack | input | 1 | Memory request completed |
| dev_in_valid | input | 1 | Inbound device byte valid |
| dev_in_data | input | 8 | Inbound device byte |
| dev_in_last | input | 1 | Inbound byte is the device's last |
| dev_in_ready | output | 1 | Engine accepts inbound byte |
| dev_out_valid | output | 1 | Outbound byte valid |
| dev_out_data | output | 8 | Outbound byte |
| dev_out_ready | input | 1 | Device accepts outbound byte |

## Verification
Two writers can meet on the interrupt flag in the same clock edge: a software write-one-to-clear at offset 2, and a set event from the device interrupt, the command kick or a completion. The bench provokes this by driving `dev_irq` in the very cycle it writes 0x04 to the status register. It then reads the flag back through the register port and expects it set. A plain clearing write without a coinciding event is expected to clear it. Transfer sweeps over region sizes, short device supply, zero-count entries and stalled outbound acceptance check data placement arithmetically against guard bytes.

// File: rtl/bmdma_engine.sv
module bmdma_engine (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  reg_addr,
  input  logic        reg_wr,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  input  logic        xfer_start,
  input  logic        xfer_dir,
  input  logic        irq_mask,
  input  logic        dev_irq,
  output logic        irq,
  output logic [7:0]  tf_status,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [7:0]  mem_wdata,
  input  logic [7:0]  mem_rdata,
  input  logic        mem_ack,
  input  logic        dev_in_valid,
  input  logic [7:0]  dev_in_data,
  input  logic        dev_in_last,
  output logic        dev_in_ready,
  output logic        dev_out_valid,
  output logic [7:0]  dev_out_data,
  input  logic        dev_out_ready
);
  localparam int DESC_BYTES = 8;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_XFER, S_DONE} state_t;

  state_t      st;
  logic [31:0] tbl_ptr, dptr, xaddr;
  logic [2:0]  bidx;
  logic [15:0] d_cnt;
  logic [16:0] rem;
  logic        d_end, dir, eod;
  logic [7:0]  hold;
  logic        hold_v;
  logic        stat_intr;

  wire act      = (st != S_IDLE);
  wire in_xfer  = (st == S_XFER);
  wire done     = (st == S_DONE);
  wire cmd_kick = reg_wr && reg_addr == 3'd0 && reg_wdata[0];
  wire w1c_intr = reg_wr && reg_addr == 3'd2 && reg_wdata[2];
  wire fire     = !irq_mask && (dev_irq || cmd_kick || done);
  wire step     = in_xfer && hold_v && (dir ? dev_out_ready : mem_ack);

  assign mem_req       = (st == S_FETCH) || (in_xfer && (dir ? !hold_v : hold_v));
  assign mem_we        = in_xfer && !dir;
  assign mem_addr      = (st == S_FETCH) ? dptr + {29'd0, bidx} : xaddr;
  assign mem_wdata     = hold;
  assign dev_in_ready  = in_xfer && !dir && !hold_v;
  assign dev_out_valid = in_xfer && dir && hold_v;
  assign dev_out_data  = hold;

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = 8'h01;
      3'd2:    reg_rdata = {5'd0, stat_intr, 1'b0, act};
      3'd4:    reg_rdata = tbl_ptr[7:0];
      3'd5:    reg_rdata = tbl_ptr[15:8];
      3'd6:    reg_rdata = tbl_ptr[23:16];
      3'd7:    reg_rdata = tbl_ptr[31:24];
      default: reg_rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      tbl_ptr   <= '0;
      dptr      <= '0;
      xaddr     <= '0;
      bidx      <= '0;
      d_cnt     <= '0;
      rem       <= '0;
      d_end     <= 1'b0;
      dir       <= 1'b0;
      eod       <= 1'b0;
      hold      <= '0;
      hold_v    <= 1'b0;
      stat_intr <= 1'b0;
      irq       <= 1'b0;
      tf_status <= 8'h50;
    end else begin
      if (reg_wr) begin
        case (reg_addr)
          3'd4: tbl_ptr[7:0]   <= reg_wdata;
          3'd5: tbl_ptr[15:8]  <= reg_wdata;
          3'd6: tbl_ptr[23:16] <= reg_wdata;
          3'd7: tbl_ptr[31:24] <= reg_wdata;
          default: ;
        endcase
      end
      stat_intr <= (stat_intr && !w1c_intr) || fire || done;
      irq       <= fire;

      case (st)
        S_IDLE: if (xfer_start) begin
          st        <= S_FETCH;
          dir       <= xfer_dir;
          dptr      <= tbl_ptr;
          bidx      <= '0;
          hold_v    <= 1'b0;
          eod       <= 1'b0;
          tf_status <= 8'h80;
        end
        S_FETCH: if (mem_ack) begin
          case (bidx)
            3'd0: xaddr[7:0]   <= mem_rdata;
            3'd1: xaddr[15:8]  <= mem_rdata;
            3'd2: xaddr[23:16] <= mem_rdata;
            3'd3: xaddr[31:24] <= mem_rdata;
            3'd4: d_cnt[7:0]   <= mem_rdata;
            3'd5: d_cnt[15:8]  <= mem_rdata;
            default: ;
          endcase
          bidx <= bidx + 3'd1;
          if (bidx == 3'd7) begin
            st    <= S_XFER;
            d_end <= mem_rdata[7];
            rem   <= (d_cnt == 16'd0) ? 17'h10000 : {1'b0, d_cnt};
            dptr  <= dptr + DESC_BYTES;
          end
        end
        S_XFER: begin
          if (!dir && !hold_v && dev_in_valid) begin
            hold   <= dev_in_data;
            hold_v <= 1'b1;
            eod    <= dev_in_last;
          end
          if (dir && !hold_v && mem_ack) begin
            hold   <= mem_rdata;
            hold_v <= 1'b1;
          end
          if (step) begin
            hold_v <= 1'b0;
            xaddr  <= xaddr + 32'd1;
            rem    <= rem - 17'd1;
            if (eod || (rem == 17'd1 && d_end)) st <= S_DONE;
            else if (rem == 17'd1) begin
              st   <= S_FETCH;
              bidx <= '0;
            end
          end
        end
        S_DONE: begin
          st        <= S_IDLE;
          tf_status <= 8'h50;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bmdma_engine_chk.sv
module bmdma_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       irq_mask,
  input logic       dev_irq,
  input logic       irq,
  input logic       act,
  input logic       intr,
  input logic [7:0] tf_status,
  input logic       mem_req,
  input logic       dev_out_valid,
  input logic       dev_out_ready,
  input logic [7:0] dev_out_data
);
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $past(irq_mask) |-> !irq); // R10
  AST_IRQ_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> intr); // R11
  AST_BUSY_TF: assert property (@(posedge clk) disable iff (!rst_n)
    act |-> tf_status == 8'h80); // R5
  AST_NO_MEM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !act |-> !mem_req); // R6
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    dev_out_valid && !dev_out_ready |=> dev_out_valid && $stable(dev_out_data)); // R9
  AST_END_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(act) |-> intr && tf_status == 8'h50); // R8
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    dev_irq && !irq_mask |=> intr); // R12
endmodule

bind bmdma_engine bmdma_engine_chk chk_i (
  .clk(clk), .rst_n(rst_n), .irq_mask(irq_mask), .dev_irq(dev_irq),
  .irq(irq), .act(act), .intr(stat_intr), .tf_status(tf_status),
  .mem_req(mem_req), .dev_out_valid(dev_out_valid),
  .dev_out_ready(dev_out_ready), .dev_out_data(dev_out_data)
);

// File: tb/bmdma_engine_tb.sv
module bmdma_engine_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [2:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_wdata = '0, reg_rdata;
  logic        xfer_start = 1'b0, xfer_dir = 1'b0, irq_mask = 1'b0, dev_irq = 1'b0;
  logic        irq, mem_req, mem_we, mem_ack, dev_in_valid, dev_in_last, dev_in_ready;
  logic        dev_out_valid, dev_out_ready;
  logic [7:0]  tf_status, mem_wdata, mem_rdata, dev_in_data, dev_out_data;
  logic [31:0] mem_addr;

  logic [7:0] mem [0:4095];
  logic [7:0] sink [0:15];
  int wr_cnt = 0, irq_cnt = 0, sink_n = 0, src_sent = 0, src_n = 0, cyc = 0;
  logic [7:0] src_base = 8'h00;
  logic src_last_en = 1'b0, src_load = 1'b0;
  logic poke_en = 1'b0;
  logic [11:0] poke_addr = '0;
  logic [7:0] poke_data = '0;
  int checks = 0, fails = 0;

  bmdma_engine dut_i (.*);

  assign mem_ack       = mem_req;
  assign mem_rdata     = mem[mem_addr[11:0]];
  assign dev_in_valid  = src_sent < src_n;
  assign dev_in_data   = src_base + 8'(src_sent);
  assign dev_in_last   = src_last_en && (src_sent == src_n - 1);
  assign dev_out_ready = cyc[0];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (poke_en) mem[poke_addr] <= poke_data;
    else if (mem_req && mem_we) begin
      mem[mem_addr[11:0]] <= mem_wdata;
      wr_cnt <= wr_cnt + 1;
    end
    if (src_load) src_sent <= 0;
    else if (dev_in_valid && dev_in_ready) src_sent <= src_sent + 1;
    if (dev_out_valid && dev_out_ready) begin
      sink[sink_n[3:0]] <= dev_out_data;
      sink_n <= sink_n + 1;
    end
  end
  always @(negedge clk) if (irq) irq_cnt <= irq_cnt + 1;

  task automatic chk(input bit ok, input string tag, input int a, input int e);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, a, e);
    end
  endtask

  task automatic wr(input [2:0] a, input [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input [2:0] a, output [7:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic poke(input [11:0] a, input [7:0] d);
    @(negedge clk); poke_en = 1'b1; poke_addr = a; poke_data = d;
    @(negedge clk); poke_en = 1'b0;
  endtask

  task automatic desc(input [11:0] t, input [31:0] ba, input [15:0] cnt, input bit last);
    poke(t, ba[7:0]); poke(t + 1, ba[15:8]); poke(t + 2, ba[23:16]); poke(t + 3, ba[31:24]);
    poke(t + 4, cnt[7:0]); poke(t + 5, cnt[15:8]); poke(t + 6, 8'h00);
    poke(t + 7, last ? 8'h80 : 8'h00);
  endtask

  task automatic set_tbl(input [31:0] p);
    wr(3'd4, p[7:0]); wr(3'd5, p[15:8]); wr(3'd6, p[23:16]); wr(3'd7, p[31:24]);
  endtask

  task automatic load_src(input int n, input [7:0] base, input bit last);
    @(negedge clk); src_n = n; src_base = base; src_last_en = last; src_load = 1'b1;
    @(negedge clk); src_load = 1'b0;
  endtask

  task automatic start(input bit d);
    @(negedge clk); xfer_dir = d; xfer_start = 1'b1;
    @(negedge clk); xfer_start = 1'b0;
  endtask

  task automatic wait_done();
    @(negedge clk);
    while (tf_status != 8'h50) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails + 1);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int w0, i0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    rd(3'd2, v); chk(v == 8'h00, "R1 status", v, 0);
    for (int k = 4; k < 8; k++) begin rd(3'(k), v); chk(v == 8'h00, "R1 tbl", v, 0); end
    chk(tf_status == 8'h50, "R1 tf", tf_status, 8'h50);
    chk(irq == 1'b0, "R1 irq", irq, 0);
    // R2
    set_tbl(32'h4433_2211);
    for (int k = 4; k < 8; k++) begin
      rd(3'(k), v); chk(v == 8'(8'h11 * (k - 3)), "R2 byte", v, 8'h11 * (k - 3));
    end
    wr(3'd5, 8'hA5);
    rd(3'd4, v); chk(v == 8'h11, "R2 lane4 kept", v, 8'h11);
    rd(3'd5, v); chk(v == 8'hA5, "R2 lane5", v, 8'hA5);
    rd(3'd6, v); chk(v == 8'h33, "R2 lane6 kept", v, 8'h33);
    // R3 / R4
    rd(3'd0, v); chk(v == 8'h01, "R3 cmd read", v, 1);
    i0 = irq_cnt; wr(3'd0, 8'h00); @(negedge clk);
    chk(irq_cnt == i0, "R3 no kick", irq_cnt - i0, 0);
    rd(3'd2, v); chk(v[2] == 1'b0, "R3 no flag", v, 0);
    wr(3'd0, 8'h01); @(negedge clk);
    chk(irq_cnt == i0 + 1, "R3 kick irq", irq_cnt - i0, 1);
    rd(3'd2, v); chk(v == 8'h04, "R3 kick flag", v, 4);
    wr(3'd2, 8'hFB); rd(3'd2, v); chk(v == 8'h04, "R4 zero keeps", v, 4);
    wr(3'd2, 8'h04); rd(3'd2, v); chk(v == 8'h00, "R4 w1c", v, 0);
    // R11
    i0 = irq_cnt;
    @(negedge clk); dev_irq = 1'b1; @(negedge clk); dev_irq = 1'b0; @(negedge clk);
    chk(irq_cnt == i0 + 1, "R11 dev irq", irq_cnt - i0, 1);
    rd(3'd2, v); chk(v[2], "R11 flag", v, 4);
    wr(3'd2, 8'h04);
    irq_mask = 1'b1; i0 = irq_cnt;
    @(negedge clk); dev_irq = 1'b1; @(negedge clk); dev_irq = 1'b0; @(negedge clk);
    chk(irq_cnt == i0, "R11 masked irq", irq_cnt - i0, 0);
    rd(3'd2, v); chk(!v[2], "R11 masked flag", v, 0);
    irq_mask = 1'b0;
    // R12
    wr(3'd0, 8'h01);
    @(negedge clk); reg_addr = 3'd2; reg_wdata = 8'h04; reg_wr = 1'b1; dev_irq = 1'b1;
    @(negedge clk); reg_wr = 1'b0; dev_irq = 1'b0;
    rd(3'd2, v); chk(v[2], "R12 set wins", v, 4);
    wr(3'd2, 8'h04); rd(3'd2, v); chk(!v[2], "R12 plain clear", v, 0);
    // R6 sweep single region sizes
    for (int n = 1; n <= 6; n++) begin
      int ba;
      ba = 12'h200 + n * 16;
      desc(12'h100, ba, 16'(n), 1'b1);
      poke(12'(ba + n), 8'hEE);
      set_tbl(32'h100);
      load_src(n + 3, 8'(n * 16), 1'b0);
      w0 = wr_cnt; i0 = irq_cnt;
      start(1'b0);
      wait_done();
      chk(wr_cnt - w0 == n, "R6 write count", wr_cnt - w0, n);
      for (int k = 0; k < n; k++)
        chk(mem[12'(ba + k)] == 8'(n * 16 + k), "R6 data", mem[12'(ba + k)], n * 16 + k);
      chk(mem[12'(ba + n)] == 8'hEE, "R6 guard", mem[12'(ba + n)], 8'hEE);
      chk(irq_cnt == i0 + 1, "R10 one irq", irq_cnt - i0, 1);
      rd(3'd2, v); chk(v == 8'h04, "R10 status", v, 4);
      wr(3'd2, 8'h04);
    end
    // R6 two regions, multi-byte address and count
    desc(12'h100, 32'h0000_0A37, 16'h0103, 1'b0);
    desc(12'h108, 32'h0000_0C00, 16'h0002, 1'b1);
    poke(12'hB3A, 8'hEE); poke(12'hC02, 8'hEE);
    load_src(300, 8'h00, 1'b0);
    w0 = wr_cnt;
    start(1'b0);
    wait_done();
    chk(wr_cnt - w0 == 261, "R6 two-entry count", wr_cnt - w0, 261);
    for (int k = 0; k < 259; k++)
      chk(mem[12'(12'hA37 + k)] == 8'(k), "R6 region0", mem[12'(12'hA37 + k)], 8'(k));
    chk(mem[12'hB3A] == 8'hEE, "R6 guard0", mem[12'hB3A], 8'hEE);
    chk(mem[12'hC00] == 8'h03 && mem[12'hC01] == 8'h04, "R6 region1", mem[12'hC01], 4);
    chk(mem[12'hC02] == 8'hEE, "R6 guard1", mem[12'hC02], 8'hEE);
    // R7 zero count with short supply
    desc(12'h100, 32'hE00, 16'h0000, 1'b1);
    load_src(6, 8'h60, 1'b1);
    w0 = wr_cnt; start(1'b0); wait_done();
    chk(wr_cnt - w0 == 6, "R7 zero count", wr_cnt - w0, 6);
    chk(mem[12'hE05] == 8'h65, "R7 data", mem[12'hE05], 8'h65);
    // R8 short supply
    wr(3'd2, 8'h04);
    desc(12'h100, 32'hF00, 16'd10, 1'b1);
    poke(12'hF04, 8'hEE);
    load_src(4, 8'h70, 1'b1);
    w0 = wr_cnt; i0 = irq_cnt; start(1'b0); wait_done();
    chk(wr_cnt - w0 == 4, "R8 count", wr_cnt - w0, 4);
    chk(mem[12'hF04] == 8'hEE, "R8 guard", mem[12'hF04], 8'hEE);
    rd(3'd2, v); chk(v == 8'h04, "R8 status", v, 4);
    chk(irq_cnt == i0 + 1, "R8 irq", irq_cnt - i0, 1);
    // R10 masked completion
    wr(3'd2, 8'h04);
    desc(12'h100, 32'hF20, 16'd2, 1'b1);
    load_src(2, 8'h00, 1'b0);
    irq_mask = 1'b1; i0 = irq_cnt;
    start(1'b0); wait_done();
    chk(irq_cnt == i0, "R10 masked", irq_cnt - i0, 0);
    rd(3'd2, v); chk(v == 8'h04, "R10 masked flag", v, 4);
    irq_mask = 1'b0;
    wr(3'd2, 8'h04);
    // R5 / R13
    desc(12'h100, 32'hF40, 16'd5, 1'b1);
    load_src(0, 8'h00, 1'b0);
    w0 = wr_cnt; i0 = irq_cnt;
    start(1'b0);
    repeat (12) @(negedge clk);
    chk(tf_status == 8'h80, "R5 tf busy", tf_status, 8'h80);
    rd(3'd2, v); chk(v == 8'h01, "R5 active", v, 1);
    start(1'b0);
    load_src(5, 8'h90, 1'b0);
    wait_done();
    chk(wr_cnt - w0 == 5, "R13 no restart", wr_cnt - w0, 5);
    chk(irq_cnt == i0 + 1, "R13 one irq", irq_cnt - i0, 1);
    // R9 outbound
    wr(3'd2, 8'h04);
    for (int k = 0; k < 3; k++) poke(12'(12'h500 + k), 8'(8'h30 + k));
    for (int k = 0; k < 4; k++) poke(12'(12'h600 + k), 8'(8'h40 + k));
    desc(12'h180, 32'h500, 16'd3, 1'b0);
    desc(12'h188, 32'h600, 16'd4, 1'b1);
    set_tbl(32'h180);
    i0 = sink_n;
    start(1'b1);
    @(negedge clk);
    while (tf_status != 8'h50) @(negedge clk);
    chk(sink_n - i0 == 7, "R9 all accepted", sink_n - i0, 7);
    for (int k = 0; k < 7; k++) begin
      int e;
      e = (k < 3) ? 8'h30 + k : 8'h40 + k - 3;
      chk(sink[4'(i0 + k)] == 8'(e), "R9 order", sink[4'(i0 + k)], e);
    end
    rd(3'd2, v); chk(v == 8'h04, "R9 status", v, 4);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule